// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Updates

The block drives four independent pulse-width outputs from one register bus. Each channel owns a small window of registers: a mode word that picks the output sense and a power-of-two clock divider, an active duty value, an active period value, and two staging registers through which software changes duty and period while the channel is live. Channels are switched on by writing ones to a set register and switched off by writing ones to a separate clear register, so software never needs a read-modify-write to touch one channel without disturbing the others. A status register shows which channels are running.

A running channel counts from zero to one less than its period on its divided clock and holds its output active while the count is below the duty value. Values staged through the update registers are copied into the active registers only on the tick where the count wraps back to zero, so every period the output produces is a complete period built from one consistent pair of values. An idle channel keeps its count at zero and parks its pin at the inactive level chosen by its polarity bit.

The bus is a plain single-cycle interface: a write is taken on the clock edge where the write strobe is high, and read data is presented combinationally while the read strobe is high.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel is stopped, every register reads zero, the status register reads zero and all four outputs are low.
- R2: A write to offset 0x04 starts every channel n whose data bit n is 1; a write to offset 0x08 stops every channel n whose data bit n is 1; data bits that are 0 leave their channels as they were. Offset 0x0C reads back the running channels, one bit per channel, channel n in bit n (0x0F with all four running).
- R3: Channel n's registers sit at 0x200 + n*0x20 plus: 0x00 mode, 0x04 active duty, 0x08 duty staging, 0x0C active period, 0x10 period staging. Duty and period values are 16 bits wide; written upper bits are dropped and read back as zero. The mode register keeps only bits 3:0 and bit 9; other bits read as zero.
- R4: Mode bits 3:0 hold a divider select p; the channel counter advances once every 2^p clock cycles, and any select above 10 behaves as 10.
- R5: A running channel counts 0 to period-1 and then wraps; its raw output is 1 while the count is below duty, so a duty of 0 gives a constant 0 and a duty at or above the period gives a constant 1.
- R6: Mode bit 9 inverts the output (0 = active high, 1 = active low). A stopped channel holds its counter at zero and drives the inactive level, which is the value of its polarity bit.
- R7: Writes to the active duty or active period register take effect at once while the channel is stopped and have no effect while it runs.
- R8: A write to a staging register stores the value (readable at the staging offset) and marks it pending; a running channel copies pending values into its active registers on the tick where its count wraps, never earlier.
- R9: Reads of any offset not listed in R2 or R3 return zero, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busRdEn | input | 1 | Read strobe; read data valid in the same cycle |
| busAddr | input | ADDR_W (10) | Byte offset of the accessed register |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data, zero when no read is requested |
| pwmOut | output | NUM_CH (4) | Per-channel pulse outputs after polarity |

## Verification
The outputs are tried with undivided and divided clocks, both polarities, a mid-range duty, a zero duty and a duty above the period, and an out-of-range divider select. Counting active cycles over whole periods confirms the duty ratio independently of phase, while measuring the length of the first active run after a channel starts pins down the divider rate, which a ratio alone cannot reveal. Staged duty and period values are read back just after the write and again after the period boundary, which separates a correct boundary-synchronised copy from an immediate one. Reads and writes at unmapped offsets and writes of upper data bits show that nothing outside the map leaks into state.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int VAL_W   = 16;
  localparam int SEL_W   = 4;
  localparam int POL_POS = 9;

  // Write strobes from the register decoder to one channel datapath
  typedef struct packed {
    logic wrMode;
    logic wrDuty;
    logic wrDutyUpd;
    logic wrPeriod;
    logic wrPeriodUpd;
  } chanStb_t;

  // Register contents one channel exposes for readback
  typedef struct packed {
    logic [SEL_W-1:0] preSel;
    logic             pol;
    logic [VAL_W-1:0] dutyAct;
    logic [VAL_W-1:0] dutyShd;
    logic [VAL_W-1:0] perAct;
    logic [VAL_W-1:0] perShd;
  } chanView_t;

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  chanView_t         views [NUM_CH],
  output chanStb_t          stb   [NUM_CH],
  output logic [NUM_CH-1:0] chanEn
);

  localparam int GLB_SET    = 'h04;
  localparam int GLB_CLR    = 'h08;
  localparam int GLB_STAT   = 'h0C;
  localparam int CH_BASE    = 'h200;
  localparam int CH_STRIDE  = 'h20;
  localparam int CH_END     = CH_BASE + NUM_CH * CH_STRIDE;
  localparam int STRIDE_LOG = $clog2(CH_STRIDE);
  localparam int CH_IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  localparam logic [STRIDE_LOG-1:0] OFF_MODE    = STRIDE_LOG'('h00);
  localparam logic [STRIDE_LOG-1:0] OFF_DUTY    = STRIDE_LOG'('h04);
  localparam logic [STRIDE_LOG-1:0] OFF_DUTYUPD = STRIDE_LOG'('h08);
  localparam logic [STRIDE_LOG-1:0] OFF_PER     = STRIDE_LOG'('h0C);
  localparam logic [STRIDE_LOG-1:0] OFF_PERUPD  = STRIDE_LOG'('h10);

  logic [ADDR_W-1:0]     relAddr;
  logic                  inWin;
  logic [CH_IDX_W-1:0]   chIdx;
  logic [STRIDE_LOG-1:0] regOff;
  logic                  offKnown;
  logic                  isSet, isClr, isStat, anyHit;
  logic [NUM_CH-1:0]     enMask;
  chanView_t             selView;

  // Address decode
  assign relAddr  = busAddr - ADDR_W'(CH_BASE);
  assign inWin    = (busAddr >= ADDR_W'(CH_BASE)) && (busAddr < ADDR_W'(CH_END));
  assign chIdx    = relAddr[STRIDE_LOG +: CH_IDX_W];
  assign regOff   = relAddr[STRIDE_LOG-1:0];
  assign offKnown = (regOff == OFF_MODE) || (regOff == OFF_DUTY) ||
                    (regOff == OFF_DUTYUPD) || (regOff == OFF_PER) ||
                    (regOff == OFF_PERUPD);
  assign isSet    = (busAddr == ADDR_W'(GLB_SET));
  assign isClr    = (busAddr == ADDR_W'(GLB_CLR));
  assign isStat   = (busAddr == ADDR_W'(GLB_STAT));
  assign anyHit   = isSet || isClr || isStat || (inWin && offKnown);

  // Channel run mask: write-one-to-set and write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
    end else if (busWrEn && isSet) begin
      enMask <= enMask | busWrData[NUM_CH-1:0];
    end else if (busWrEn && isClr) begin
      enMask <= enMask & ~busWrData[NUM_CH-1:0];
    end
  end

  assign chanEn = enMask;

  // Per-channel write strobes; direct duty/period writes only when stopped
  for (genvar c = 0; c < NUM_CH; c++) begin : g_stb
    logic hitC;
    assign hitC = busWrEn && inWin && (chIdx == CH_IDX_W'(c));
    assign stb[c] = '{
      wrMode:      hitC && (regOff == OFF_MODE),
      wrDuty:      hitC && (regOff == OFF_DUTY) && !enMask[c],
      wrDutyUpd:   hitC && (regOff == OFF_DUTYUPD),
      wrPeriod:    hitC && (regOff == OFF_PER) && !enMask[c],
      wrPeriodUpd: hitC && (regOff == OFF_PERUPD)
    };
  end

  // Readback
  always_comb begin
    selView = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chIdx == CH_IDX_W'(c)) selView = views[c];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (isStat) begin
        busRdData = DATA_W'(enMask);
      end else if (inWin) begin
        case (regOff)
          OFF_MODE: begin
            busRdData[SEL_W-1:0] = selView.preSel;
            busRdData[POL_POS]   = selView.pol;
          end
          OFF_DUTY:    busRdData = DATA_W'(selView.dutyAct);
          OFF_DUTYUPD: busRdData = DATA_W'(selView.dutyShd);
          OFF_PER:     busRdData = DATA_W'(selView.perAct);
          OFF_PERUPD:  busRdData = DATA_W'(selView.perShd);
          default:     busRdData = '0;
        endcase
      end
    end
  end

  AST_SET_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && isSet) |=> ((chanEn & $past(busWrData[NUM_CH-1:0])) == $past(busWrData[NUM_CH-1:0]))); // R2

  AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && isClr) |=> ((chanEn & $past(busWrData[NUM_CH-1:0])) == '0)); // R2

  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !anyHit) |=> $stable(chanEn)); // R9

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  chanStb_t         stb,
  input  logic [VAL_W-1:0] wrVal,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             wrPol,
  output chanView_t        view,
  output logic             pwmOut
);

  localparam int PRE_W = (PRE_MAX > 0) ? PRE_MAX : 1;

  logic [SEL_W-1:0] preSel, effSel;
  logic             pol;
  logic [VAL_W-1:0] dutyAct, dutyShd, perAct, perShd, cnt;
  logic             pendDuty, pendPer;
  logic [PRE_W-1:0] preCnt, preMask;
  logic             tick, wrapNow;
  logic [VAL_W:0]   nextCnt;

  // Divider: clamp select, tick when the low p bits of the free counter are all ones
  assign effSel  = (preSel > SEL_W'(PRE_MAX)) ? SEL_W'(PRE_MAX) : preSel;
  assign preMask = ~({PRE_W{1'b1}} << effSel);
  assign tick    = en && ((preCnt & preMask) == preMask);
  assign nextCnt = {1'b0, cnt} + 1'b1;
  assign wrapNow = tick && (nextCnt >= {1'b0, perAct});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSel <= '0;
      pol    <= 1'b0;
    end else if (stb.wrMode) begin
      preSel <= wrSel;
      pol    <= wrPol;
    end
  end

  // Divider and period counter
  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      preCnt <= '0;
      cnt    <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (tick) cnt <= wrapNow ? '0 : nextCnt[VAL_W-1:0];
    end
  end

  // Active duty: staged copy at wrap, direct write while stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyAct  <= '0;
      dutyShd  <= '0;
      pendDuty <= 1'b0;
    end else begin
      if (wrapNow && pendDuty) begin
        dutyAct  <= dutyShd;
        pendDuty <= 1'b0;
      end else if (stb.wrDuty) begin
        dutyAct <= wrVal;
      end
      if (stb.wrDutyUpd) begin
        dutyShd  <= wrVal;
        pendDuty <= 1'b1;
      end
    end
  end

  // Active period: same rule
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perAct  <= '0;
      perShd  <= '0;
      pendPer <= 1'b0;
    end else begin
      if (wrapNow && pendPer) begin
        perAct  <= perShd;
        pendPer <= 1'b0;
      end else if (stb.wrPeriod) begin
        perAct <= wrVal;
      end
      if (stb.wrPeriodUpd) begin
        perShd  <= wrVal;
        pendPer <= 1'b1;
      end
    end
  end

  assign pwmOut = (en && (cnt < dutyAct)) ^ pol;

  assign view = '{preSel: preSel, pol: pol, dutyAct: dutyAct, dutyShd: dutyShd,
                  perAct: perAct, perShd: perShd};

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (en && (perAct != '0)) |-> (cnt < perAct)); // R5

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (cnt == '0)); // R6

  AST_DUTY_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (en && !wrapNow) |=> $stable(dutyAct)); // R7

  AST_PERIOD_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (en && !wrapNow) |=> $stable(perAct)); // R8

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int PRE_MAX = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  chanView_t         views [NUM_CH];
  chanStb_t          stb   [NUM_CH];
  logic [NUM_CH-1:0] chanEn;

  pwm_bank_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .views(views), .stb(stb), .chanEn(chanEn)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_bank_chan #(.PRE_MAX(PRE_MAX)) u_chan (
      .clk(clk), .rstN(rstN), .en(chanEn[c]), .stb(stb[c]),
      .wrVal(busWrData[VAL_W-1:0]), .wrSel(busWrData[SEL_W-1:0]),
      .wrPol(busWrData[POL_POS]),
      .view(views[c]), .pwmOut(pwmOut[c])
    );
  end

endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  pwmOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } rdItem_t;
  rdItem_t rdQ[$];

  always #10 clk = ~clk;

  pwm_bank uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pwmOut(pwmOut)
  );

  function automatic logic [9:0] chAddr(int ch, int off);
    return 10'('h200 + ch * 'h20 + off);
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  // Driver: pushes the expected value, monitor compares at the negedge
  task automatic rdExpect(logic [9:0] a, logic [31:0] exp, string tag);
    rdItem_t it;
    it.exp = exp; it.tag = tag;
    @(posedge clk); #1;
    busRdEn = 1'b1; busAddr = a;
    rdQ.push_back(it);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  always @(negedge clk) begin
    if (busRdEn) begin
      checks++;
      if (rdQ.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", busRdData);
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        if (busRdData !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, busRdData, it.exp);
        end
      end
    end
  end

  // Length of the run at level lvl starting at the next negedge
  task automatic runLen(int ch, logic lvl, output int n);
    n = 0;
    @(negedge clk);
    while (pwmOut[ch] == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic countHigh(int ch, int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut[ch]) n++;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 outputs after reset", pwmOut, 0);
    rdExpect(10'h00C, 32'h0, "R1 status after reset");
    rdExpect(chAddr(0, 'h04), 32'h0, "R1 duty after reset");

    // R9 unmapped offsets
    rdExpect(10'h000, 32'h0, "R9 read 0x000");
    rdExpect(10'h100, 32'h0, "R9 read 0x100");
    rdExpect(chAddr(0, 'h14), 32'h0, "R9 read channel gap");
    wrReg(10'h100, 32'hF);
    wrReg(10'h280, 32'hFFFF);
    rdExpect(10'h00C, 32'h0, "R9 write to unmapped ignored");
    rdExpect(10'h280, 32'h0, "R9 read past last channel");

    // R3 field widths, ch0 p=0 pol=0 period 10 duty 3
    wrReg(chAddr(0, 'h00), 32'hFFFF_FC00);
    rdExpect(chAddr(0, 'h00), 32'h0, "R3 mode keeps only its fields");
    wrReg(chAddr(0, 'h04), 32'hABCD_0003);
    rdExpect(chAddr(0, 'h04), 32'h0000_0003, "R3 duty upper bits dropped");
    wrReg(chAddr(0, 'h0C), 32'h0001_000A);
    rdExpect(chAddr(0, 'h0C), 32'h0000_000A, "R3 period upper bits dropped");

    wrReg(10'h004, 32'h1);
    runLen(0, 1'b1, n);
    checkVal("R5 first active run ch0", n, 3 << 0);
    countHigh(0, 40, n);
    checkVal("R5 duty ratio ch0", n, 12);
    rdExpect(10'h00C, 32'h1, "R2 status one channel");

    // R7 direct write while running ignored
    wrReg(chAddr(0, 'h04), 32'h7);
    rdExpect(chAddr(0, 'h04), 32'h3, "R7 duty held while running");
    countHigh(0, 40, n);
    checkVal("R7 output unchanged", n, 12);

    // ch1 inverted, p=1, period 8 duty 2
    wrReg(chAddr(1, 'h00), 32'h0000_0201);
    wrReg(chAddr(1, 'h0C), 32'd8);
    wrReg(chAddr(1, 'h04), 32'd2);
    rdExpect(chAddr(1, 'h00), 32'h0000_0201, "R6 mode readback");
    @(negedge clk);
    checkVal("R6 idle inverted level", pwmOut[1], 1);
    wrReg(10'h004, 32'h2);
    runLen(1, 1'b0, n);
    checkVal("R4 divided active run ch1", n, 2 << 1);
    countHigh(1, 32, n);
    checkVal("R6 inverted ratio ch1", n, 32 - 8);
    rdExpect(10'h00C, 32'h3, "R2 zero bits leave channels");

    // ch2 duty above period, then duty zero
    wrReg(chAddr(2, 'h0C), 32'd5);
    wrReg(chAddr(2, 'h04), 32'd7);
    wrReg(10'h004, 32'h4);
    countHigh(2, 20, n);
    checkVal("R5 duty above period", n, 20);
    wrReg(10'h008, 32'h4);
    rdExpect(10'h00C, 32'h3, "R2 clear one channel");
    @(negedge clk);
    checkVal("R6 stopped normal level", pwmOut[2], 0);
    wrReg(chAddr(2, 'h04), 32'd0);
    wrReg(10'h004, 32'h4);
    countHigh(2, 20, n);
    checkVal("R5 zero duty", n, 0);
    wrReg(10'h008, 32'h4);

    // R8 staged updates on ch3: p=2, period 50, duty 10
    wrReg(chAddr(3, 'h00), 32'h2);
    wrReg(chAddr(3, 'h0C), 32'd50);
    wrReg(chAddr(3, 'h04), 32'd10);
    wrReg(10'h004, 32'h8);
    wrReg(chAddr(3, 'h08), 32'd5);
    wrReg(chAddr(3, 'h10), 32'd20);
    rdExpect(chAddr(3, 'h04), 32'd10, "R8 duty not yet copied");
    rdExpect(chAddr(3, 'h0C), 32'd50, "R8 period not yet copied");
    rdExpect(chAddr(3, 'h08), 32'd5, "R8 duty staging readback");
    rdExpect(chAddr(3, 'h10), 32'd20, "R8 period staging readback");
    repeat (250) @(posedge clk);
    rdExpect(chAddr(3, 'h04), 32'd5, "R8 duty copied at wrap");
    rdExpect(chAddr(3, 'h0C), 32'd20, "R8 period copied at wrap");
    countHigh(3, 2 * 20 * 4, n);
    checkVal("R8 new ratio ch3", n, 2 * 5 * 4);

    // R4 select above 10 clamps to 10
    wrReg(chAddr(2, 'h00), 32'hF);
    wrReg(chAddr(2, 'h0C), 32'd2);
    wrReg(chAddr(2, 'h04), 32'd1);
    wrReg(10'h004, 32'h4);
    runLen(2, 1'b1, n);
    checkVal("R4 clamped divider", n, 1 << 10);
    rdExpect(10'h00C, 32'hF, "R2 all channels running");

    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule